// File: doc/BRIEF.md
# Sprite Scanline Pixel Store

This block keeps the sprite pixels for two scanlines in a ping-pong pair of halves. During any line, one half is the render side: the sprite renderer writes pixels into it for the coming line. The other half is the scan side: the mixer reads it pixel by pixel for the line now on screen. A one-cycle line-swap strobe, given once per line, exchanges the roles of the two halves. Background planes never pass through this store; only sprite pixels do.

A scan read returns the stored pixel and erases that location in the same cycle, so the half is clean when it becomes the render side again. The erase only happens for pixels that are actually shown. When the whole display is off, or when the leftmost-column blanking hides the first pixels of the line, those locations are neither returned nor erased. Their stale sprite data lasts into later lines. With the display off, nothing is written into the render side either. Sprites for the first line of a frame are drawn while the last line of the previous frame is on screen, so the renderer needs no special case at the frame boundary.

Top module: `sprite_line_buffer`

## Requirements
- R1: After reset, every location of both halves is transparent (value 0), `rd_color` and `rd_prio` are 0, and half 0 is the render side.
- R2: A pixel written into the render side during a line is returned by a scan read of the same x position after exactly one line-swap strobe. The result is returned as `rd_prio` (priority) and `rd_color` (6-bit colour).
- R3: A scan read that returns a pixel also erases that location. A second read of the same x position, whether in the same line or in a later line, returns 0 until the location is written again.
- R4: A render write is ignored when the target location already holds a non-transparent pixel, so the first sprite drawn wins. A render write whose colour is 0 is ignored as well.
- R5: While `disp_en` is 0, scan reads return 0 and erase nothing, and render writes change nothing.
- R6: While `col_blank` is 1, scan reads at x positions 0 to 7 return 0 and erase nothing. Reads at x of 8 and above behave normally.
- R7: A render write and a scan read in the same cycle, at any pair of positions, do not disturb each other. The read returns the scan-side value as it was before that cycle.
- R8: Each cycle with `line_swap` high exchanges the roles of the halves after that cycle. A read or write issued in the same cycle as the strobe still uses the roles held before it.
- R9: A read at an x of 320 or more returns 0. A write at such an x changes nothing.
- R10: `rd_color` and `rd_prio` carry the result of the read issued in the previous cycle. They are 0 in any cycle that follows a cycle with `rd_en` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_swap | input | 1 | One-cycle strobe that exchanges the render and scan halves |
| disp_en | input | 1 | Display enable; 0 freezes both halves |
| col_blank | input | 1 | Leftmost-column blanking of the first 8 pixels |
| wr_en | input | 1 | Render write request |
| wr_x | input | 9 | Render write x position |
| wr_color | input | 6 | Render colour index; 0 is transparent |
| wr_prio | input | 1 | Render priority bit |
| rd_en | input | 1 | Scan read request |
| rd_x | input | 9 | Scan read x position |
| rd_color | output | 6 | Colour returned one cycle after the read |
| rd_prio | output | 1 | Priority returned one cycle after the read |

## Verification
The bench goes after the cases where an erase is skipped. If the design erased regardless of blanking, the eight leftmost pixels from the first line would read back as zero three lines later instead of keeping their stale values. If it accepted writes with the display off, the cleared half would show new pixels after the next swap. It also probes the swap-cycle boundary: a write issued with the strobe goes into the old render half, so a design that switched roles early would put that pixel in the wrong line. Overwrite attempts on filled locations, and transparent writes into empty ones, would show up as changed colours if the first-wins rule were broken. A second read of a location just shown catches a missing erase.

// File: rtl/sprlb_pkg.sv
package sprlb_pkg;

    localparam int COLOR_W = 6;

    typedef struct packed {
        logic               prio;
        logic [COLOR_W-1:0] color;
    } spx_t;

    localparam spx_t SPX_CLEAR = '0;

    function automatic logic spx_opaque(spx_t p);
        return p.color != '0;
    endfunction

    function automatic spx_t spx_make(logic [COLOR_W-1:0] c, logic pr);
        spx_t p;
        p.prio  = pr;
        p.color = c;
        return p;
    endfunction

endpackage

// File: rtl/sprlb_bank.sv
module sprlb_bank
    import sprlb_pkg::*;
#(
    parameter int DEPTH = 320,
    parameter int XW    = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          put_en,
    input  logic [XW-1:0] put_x,
    input  spx_t          put_pix,
    input  logic          take_en,
    input  logic [XW-1:0] take_x,
    output spx_t          take_pix
);

    spx_t mem [DEPTH];

    assign take_pix = mem[take_x];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= SPX_CLEAR;
            end
        end else begin
            if (take_en) begin
                mem[take_x] <= SPX_CLEAR;
            end
            if (put_en && !spx_opaque(mem[put_x])) begin
                mem[put_x] <= put_pix;
            end
        end
    end

endmodule

// File: rtl/sprlb_ctrl.sv
module sprlb_ctrl
    import sprlb_pkg::*;
#(
    parameter int LINE_W     = 320,
    parameter int BLANK_COLS = 8,
    parameter int XW         = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_swap,
    input  logic               disp_en,
    input  logic               col_blank,
    input  logic               wr_en,
    input  logic [XW-1:0]      wr_x,
    input  logic [COLOR_W-1:0] wr_color,
    input  logic               rd_en,
    input  logic [XW-1:0]      rd_x,
    output logic               render_sel,
    output logic               rd_ok,
    output logic [1:0]         put_en,
    output logic [1:0]         take_en
);

    localparam logic [XW:0] X_LIM = (XW + 1)'(LINE_W);
    localparam logic [XW:0] B_LIM = (XW + 1)'(BLANK_COLS);

    logic wr_ok;
    logic rd_in_edge;

    assign rd_in_edge = col_blank && ({1'b0, rd_x} < B_LIM);
    assign wr_ok = wr_en && disp_en && ({1'b0, wr_x} < X_LIM) && (wr_color != '0);
    assign rd_ok = rd_en && disp_en && ({1'b0, rd_x} < X_LIM) && !rd_in_edge;

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign put_en[h]  = wr_ok && (render_sel == 1'(h));
        assign take_en[h] = rd_ok && (render_sel != 1'(h));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            render_sel <= 1'b0;
        end else if (line_swap) begin
            render_sel <= ~render_sel;
        end
    end

endmodule

// File: rtl/sprlb_rdout.sv
module sprlb_rdout
    import sprlb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_ok,
    input  logic render_sel,
    input  spx_t half0_pix,
    input  spx_t half1_pix,
    output spx_t out_pix
);

    spx_t scan_pix;

    assign scan_pix = render_sel ? half0_pix : half1_pix;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_pix <= SPX_CLEAR;
        end else if (rd_ok) begin
            out_pix <= scan_pix;
        end else begin
            out_pix <= SPX_CLEAR;
        end
    end

endmodule

// File: rtl/sprite_line_buffer.sv
module sprite_line_buffer
    import sprlb_pkg::*;
#(
    parameter int LINE_W     = 320,
    parameter int BLANK_COLS = 8,
    localparam int XW        = $clog2(LINE_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_swap,
    input  logic               disp_en,
    input  logic               col_blank,
    input  logic               wr_en,
    input  logic [XW-1:0]      wr_x,
    input  logic [COLOR_W-1:0] wr_color,
    input  logic               wr_prio,
    input  logic               rd_en,
    input  logic [XW-1:0]      rd_x,
    output logic [COLOR_W-1:0] rd_color,
    output logic               rd_prio
);

    logic       render_sel;
    logic       rd_ok;
    logic [1:0] put_en;
    logic [1:0] take_en;
    spx_t       wr_pix;
    spx_t       half_pix [2];
    spx_t       out_pix;

    assign wr_pix = spx_make(wr_color, wr_prio);

    sprlb_ctrl #(
        .LINE_W     (LINE_W),
        .BLANK_COLS (BLANK_COLS),
        .XW         (XW)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .line_swap  (line_swap),
        .disp_en    (disp_en),
        .col_blank  (col_blank),
        .wr_en      (wr_en),
        .wr_x       (wr_x),
        .wr_color   (wr_color),
        .rd_en      (rd_en),
        .rd_x       (rd_x),
        .render_sel (render_sel),
        .rd_ok      (rd_ok),
        .put_en     (put_en),
        .take_en    (take_en)
    );

    for (genvar h = 0; h < 2; h++) begin : g_bank
        sprlb_bank #(
            .DEPTH (LINE_W),
            .XW    (XW)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .put_en   (put_en[h]),
            .put_x    (wr_x),
            .put_pix  (wr_pix),
            .take_en  (take_en[h]),
            .take_x   (rd_x),
            .take_pix (half_pix[h])
        );
    end

    sprlb_rdout u_rdout (
        .clk        (clk),
        .rst        (rst),
        .rd_ok      (rd_ok),
        .render_sel (render_sel),
        .half0_pix  (half_pix[0]),
        .half1_pix  (half_pix[1]),
        .out_pix    (out_pix)
    );

    assign rd_color = out_pix.color;
    assign rd_prio  = out_pix.prio;

endmodule

// File: rtl/sprite_line_buffer_chk.sv
module sprite_line_buffer_chk #(
    parameter int LINE_W     = 320,
    parameter int BLANK_COLS = 8,
    parameter int XW         = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          line_swap,
    input logic          disp_en,
    input logic          col_blank,
    input logic          rd_en,
    input logic [XW-1:0] rd_x,
    input logic [5:0]    wr_color,
    input logic [5:0]    rd_color,
    input logic          rd_prio,
    input logic          render_sel,
    input logic [1:0]    put_en,
    input logic [1:0]    take_en
);

    localparam logic [XW:0] X_LIM = (XW + 1)'(LINE_W);
    localparam logic [XW:0] B_LIM = (XW + 1)'(BLANK_COLS);

    assert_idle_dark_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_color == '0 && !rd_prio));

    assert_off_dark_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !disp_en) |=> (rd_color == '0 && !rd_prio));

    assert_off_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        !disp_en |-> (put_en == 2'b00 && take_en == 2'b00));

    assert_edge_dark_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && col_blank && {1'b0, rd_x} < B_LIM) |=> (rd_color == '0 && !rd_prio));

    assert_far_dark_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && {1'b0, rd_x} >= X_LIM) |=> (rd_color == '0 && !rd_prio));

    assert_clear_write_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_color == '0) |-> (put_en == 2'b00));

    assert_swap_flip_R8: assert property (@(posedge clk) disable iff (rst)
        line_swap |=> (render_sel != $past(render_sel)));

    assert_swap_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !line_swap |=> $stable(render_sel));

    assert_split_halves_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(put_en) && $onehot0(take_en) && ((put_en & take_en) == 2'b00));

endmodule

bind sprite_line_buffer sprite_line_buffer_chk #(
    .LINE_W     (LINE_W),
    .BLANK_COLS (BLANK_COLS),
    .XW         (XW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_swap  (line_swap),
    .disp_en    (disp_en),
    .col_blank  (col_blank),
    .rd_en      (rd_en),
    .rd_x       (rd_x),
    .wr_color   (wr_color),
    .rd_color   (rd_color),
    .rd_prio    (rd_prio),
    .render_sel (render_sel),
    .put_en     (put_en),
    .take_en    (take_en)
);

// File: tb/sprite_line_buffer_bench.sv
module sprite_line_buffer_bench;

    localparam int W  = 320;
    localparam int BC = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_swap = 1'b0;
    logic       disp_en = 1'b0;
    logic       col_blank = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_x = '0;
    logic [5:0] wr_color = '0;
    logic       wr_prio = 1'b0;
    logic       rd_en = 1'b0;
    logic [8:0] rd_x = '0;
    logic [5:0] rd_color;
    logic       rd_prio;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [6:0] model [2][W];
    int msel = 0;

    always #4 clk = ~clk;

    sprite_line_buffer u_sprite_line_buffer (
        .clk       (clk),
        .rst       (rst),
        .line_swap (line_swap),
        .disp_en   (disp_en),
        .col_blank (col_blank),
        .wr_en     (wr_en),
        .wr_x      (wr_x),
        .wr_color  (wr_color),
        .wr_prio   (wr_prio),
        .rd_en     (rd_en),
        .rd_x      (rd_x),
        .rd_color  (rd_color),
        .rd_prio   (rd_prio)
    );

    function automatic logic [5:0] pat_a(int x);
        return 6'((x * 5 + 1) % 63 + 1);
    endfunction

    function automatic logic [5:0] pat_b(int x);
        return 6'((x * 11 + 7) % 63 + 1);
    endfunction

    function automatic logic [5:0] pat_c(int x);
        return 6'((x * 3 + 20) % 63 + 1);
    endfunction

    task automatic check(string tag, logic [6:0] got, logic [6:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, compute the expected result, sample at next negedge
    task automatic step(input bit sw, input bit de, input bit cb,
                        input bit we, input int wx, input logic [5:0] wc, input bit wp,
                        input bit re, input int rx, input string tag);
        logic [6:0] exp;
        line_swap = sw; disp_en = de; col_blank = cb;
        wr_en = we; wr_x = 9'(wx); wr_color = wc; wr_prio = wp;
        rd_en = re; rd_x = 9'(rx);
        exp = '0;
        if (re && de && rx < W && !(cb && rx < BC)) begin
            exp = model[1 - msel][rx];
            model[1 - msel][rx] = '0;
        end
        if (we && de && wx < W && wc != 0 && model[msel][wx] == 0) begin
            model[msel][wx] = {wp, wc};
        end
        if (sw) msel = 1 - msel;
        @(posedge clk);
        @(negedge clk);
        check(tag, {rd_prio, rd_color}, exp);
    endtask

    task automatic idle(input string tag);
        step(0, 1, 0, 0, 0, 6'd0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int h = 0; h < 2; h++)
            for (int x = 0; x < W; x++)
                model[h][x] = '0;
        repeat (3) @(negedge clk);
        check("R1", {rd_prio, rd_color}, 7'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {rd_prio, rd_color}, 7'd0);

        // R1: both halves empty after reset
        for (int x = 0; x < W; x++) step(0, 1, 0, 0, 0, 6'd0, 0, 1, x, "R1");
        step(1, 1, 0, 0, 0, 6'd0, 0, 0, 0, "R8");
        for (int x = 0; x < W; x++) step(0, 1, 0, 0, 0, 6'd0, 0, 1, x, "R1");
        step(1, 1, 0, 0, 0, 6'd0, 0, 0, 0, "R8");

        // line A: fill half 0 while scanning empty half 1 (R7)
        for (int x = 0; x < 300; x++) step(0, 1, 0, 1, x, pat_a(x), x[0], 1, x, "R7");
        // R4: overwrite attempts on filled locations
        for (int x = 0; x < 300; x++) step(0, 1, 0, 1, x, pat_b(x), ~x[0], 0, 0, "R4");
        // R8: write in the swap cycle lands in the old render half
        step(1, 1, 0, 1, 300, 6'd42, 1, 1, 9, "R8");

        // line B: scan half 0 with column blanking, render alternating into half 1
        for (int x = 0; x < W; x++)
            step(0, 1, 1, 1, x, x[0] ? 6'd0 : pat_c(x), 1, 1, x, x < BC ? "R6" : "R2");
        step(0, 1, 1, 0, 0, 6'd0, 0, 1, 20, "R3");
        step(0, 1, 0, 0, 0, 6'd0, 0, 1, 3, "R6");
        step(0, 1, 0, 0, 0, 6'd0, 0, 1, 3, "R3");
        for (int x = W; x < W + 11; x++) step(0, 1, 0, 1, x + 1, 6'd9, 0, 1, x, "R9");
        step(1, 1, 0, 0, 0, 6'd0, 0, 0, 0, "R8");

        // line C: display off freezes both halves (R5)
        for (int x = 0; x < W; x++) step(0, 0, 0, 1, x, pat_b(x), 1, 1, x, "R5");
        for (int x = 0; x < W; x++)
            step(0, 1, 0, 0, 0, 6'd0, 0, 1, x, x[0] ? "R4" : "R2");
        for (int k = 0; k < 4; k++) idle("R10");
        step(1, 1, 0, 0, 0, 6'd0, 0, 0, 0, "R8");

        // line D: stale left pixels survive, nothing written while off
        for (int x = 0; x < W; x++) step(0, 1, 0, 0, 0, 6'd0, 0, 1, x, x < BC ? "R6" : "R5");
        step(1, 1, 0, 0, 0, 6'd0, 0, 0, 0, "R8");
        step(1, 1, 0, 0, 0, 6'd0, 0, 0, 0, "R8");
        // R3: everything read in line D is gone two swaps later
        for (int x = 0; x < W; x++) step(0, 1, 0, 0, 0, 6'd0, 0, 1, x, "R3");
        idle("R10");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule